// File: doc/BRIEF.md
# Register Writer-Tag Table with Result Snooping

This block sits beside the issue stage of a dynamically scheduled floating-point pipeline. For every architectural register it stores the register's value and a writer tag. The writer tag names the reservation station that will produce the register's next value, or it holds zero when no instruction in flight targets that register. When an instruction issues, two source lookups return either a ready value or the tag of the station to wait for. In the same cycle, the destination register's writer tag is replaced with the tag of the issuing station.

The block watches the shared result bus. A register takes a broadcast value only when the broadcast tag equals its current writer tag, and that writer tag then returns to empty. An older producer whose tag has already been replaced by a younger writer is ignored. Write-after-write ordering is therefore kept without stalling issue. A source lookup whose pending tag is on the bus in the same cycle gets the bus value directly and reports it as ready.

Top module: `regstat_table`

## Requirements
- R1: After reset every writer tag is empty (0) and every register value is zero, so every source lookup reports ready with value 0 and tag 0.
- R2: A source lookup of a register whose writer tag is empty reports ready=1, tag 0 and the stored value. A lookup of a register with a pending writer (not on the bus this cycle) reports ready=0, the writer tag, and the stored value.
- R3: An issue (iss_valid=1) sets the writer tag of register iss_dst to iss_tag from the next cycle on, even when another writer was already pending.
- R4: A broadcast changes a register's value only when bus_tag equals that register's non-empty writer tag. A broadcast with an older, replaced tag leaves both the value and the tag untouched.
- R5: After a matching broadcast with no issue to the same register, that register's writer tag is empty and its value is the broadcast data.
- R6: When an issue to a register and a matching broadcast for that register happen in the same cycle, the new issue tag is kept and the value still takes the broadcast data.
- R7: A source lookup of a register whose pending writer tag equals bus_tag while bus_valid=1 reports ready=1, tag 0 and value bus_data in that same cycle.
- R8: With bus_valid=0, or with bus_tag=0, no register's value or tag changes, apart from issue updates.
- R9: Source lookups show the state before the same-cycle issue. An instruction that names its own destination as a source sees the previous writer, not itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_tag | input | TAG_W | Station tag of the issuing instruction (non-zero) |
| iss_dst | input | IDX_W | Destination register index |
| iss_src1 | input | IDX_W | First source register index |
| iss_src2 | input | IDX_W | Second source register index |
| src1_ready | output | 1 | First source value is available |
| src1_value | output | DATA_W | First source value (stored or bypassed) |
| src1_tag | output | TAG_W | First source pending writer, 0 when ready |
| src2_ready | output | 1 | Second source value is available |
| src2_value | output | DATA_W | Second source value (stored or bypassed) |
| src2_tag | output | TAG_W | Second source pending writer, 0 when ready |
| bus_valid | input | 1 | Result broadcast present |
| bus_tag | input | TAG_W | Tag of the broadcasting station |
| bus_data | input | DATA_W | Broadcast result |

## Verification
The bench goes after write-after-write renaming first. A stale broadcast from a replaced writer must leave the register untouched; a design that matched on any pending tag would let an old result overwrite the newer one and clear a tag that is still live. It drives an issue and a matching broadcast to the same register in one cycle: getting the priority wrong either loses the new tag, so the instruction is never awaited, or drops the data. It also checks same-cycle bypass, where a missing path leaves a consumer waiting on a tag that will never appear again, and a self-referencing issue that must not wait on itself. A long stretch of mixed issue and broadcast traffic then runs against a behavioural model.

// File: rtl/regstat_pkg.sv
package regstat_pkg;
   localparam int RS_DEF_REGS   = 16;
   localparam int RS_DEF_DATA_W = 64;
   localparam int RS_DEF_TAG_W  = 4;

   // where a source lookup takes its answer from
   typedef enum logic [1:0] {
      RD_FROM_REG  = 2'd0,
      RD_FROM_BUS  = 2'd1,
      RD_MUST_WAIT = 2'd2
   } rd_src_e;
endpackage

// File: rtl/regstat_entry.sv
module regstat_entry #(
   parameter int DATA_W = 64,
   parameter int TAG_W  = 4,
   parameter int IDX_W  = 4,
   parameter int IDX    = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_valid,
   input  logic [IDX_W-1:0]  iss_dst,
   input  logic [TAG_W-1:0]  iss_tag,
   input  logic              bus_valid,
   input  logic [TAG_W-1:0]  bus_tag,
   input  logic [DATA_W-1:0] bus_data,
   output logic [TAG_W-1:0]  stat_q,
   output logic [DATA_W-1:0] val_q
);
   localparam logic [IDX_W-1:0] MY_IDX = IDX[IDX_W-1:0];

   logic hit_bus;
   logic hit_iss;

   assign hit_bus = bus_valid && (stat_q != '0) && (bus_tag == stat_q);
   assign hit_iss = iss_valid && (iss_dst == MY_IDX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q <= '0;
         val_q  <= '0;
      end else begin
         if (hit_bus) val_q <= bus_data;
         if (hit_iss)      stat_q <= iss_tag;
         else if (hit_bus) stat_q <= '0;
      end
   end
endmodule

// File: rtl/regstat_read.sv
module regstat_read
   import regstat_pkg::*;
#(
   parameter int NUM_REGS = 16,
   parameter int DATA_W   = 64,
   parameter int TAG_W    = 4,
   parameter bit BYPASS   = 1'b1,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic [IDX_W-1:0]                 idx,
   input  logic [NUM_REGS-1:0][TAG_W-1:0]   stat_flat,
   input  logic [NUM_REGS-1:0][DATA_W-1:0]  val_flat,
   input  logic                             bus_valid,
   input  logic [TAG_W-1:0]                 bus_tag,
   input  logic [DATA_W-1:0]                bus_data,
   output logic                             ready,
   output logic [DATA_W-1:0]                value,
   output logic [TAG_W-1:0]                 tag
);
   logic [TAG_W-1:0] cur_tag;
   logic             on_bus;
   rd_src_e          from;

   assign cur_tag = stat_flat[idx];

   generate
      if (BYPASS) begin : g_bypass
         assign on_bus = bus_valid && (cur_tag != '0) && (bus_tag == cur_tag);
      end else begin : g_no_bypass
         assign on_bus = 1'b0;
      end
   endgenerate

   always_comb begin
      if (cur_tag == '0) from = RD_FROM_REG;
      else if (on_bus)   from = RD_FROM_BUS;
      else               from = RD_MUST_WAIT;
   end

   always_comb begin
      unique case (from)
         RD_FROM_BUS: begin
            ready = 1'b1;
            value = bus_data;
            tag   = '0;
         end
         RD_MUST_WAIT: begin
            ready = 1'b0;
            value = val_flat[idx];
            tag   = cur_tag;
         end
         default: begin
            ready = 1'b1;
            value = val_flat[idx];
            tag   = '0;
         end
      endcase
   end
endmodule

// File: rtl/regstat_table.sv
module regstat_table
   import regstat_pkg::*;
#(
   parameter int NUM_REGS = RS_DEF_REGS,
   parameter int DATA_W   = RS_DEF_DATA_W,
   parameter int TAG_W    = RS_DEF_TAG_W,
   parameter bit BYPASS   = 1'b1,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_valid,
   input  logic [TAG_W-1:0]  iss_tag,
   input  logic [IDX_W-1:0]  iss_dst,
   input  logic [IDX_W-1:0]  iss_src1,
   input  logic [IDX_W-1:0]  iss_src2,
   output logic              src1_ready,
   output logic [DATA_W-1:0] src1_value,
   output logic [TAG_W-1:0]  src1_tag,
   output logic              src2_ready,
   output logic [DATA_W-1:0] src2_value,
   output logic [TAG_W-1:0]  src2_tag,
   input  logic              bus_valid,
   input  logic [TAG_W-1:0]  bus_tag,
   input  logic [DATA_W-1:0] bus_data
);
   generate
      if (NUM_REGS < 2 || (1 << IDX_W) != NUM_REGS) begin : g_bad_regs
         $error("regstat_table: NUM_REGS must be a power of two, at least 2");
      end
      if (TAG_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("regstat_table: TAG_W and DATA_W must be positive");
      end
   endgenerate

   logic [NUM_REGS-1:0][TAG_W-1:0]  stat_flat;
   logic [NUM_REGS-1:0][DATA_W-1:0] val_flat;

   generate
      for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
         regstat_entry #(
            .DATA_W(DATA_W), .TAG_W(TAG_W), .IDX_W(IDX_W), .IDX(r)
         ) u_entry (
            .clk      (clk),
            .rst_n    (rst_n),
            .iss_valid(iss_valid),
            .iss_dst  (iss_dst),
            .iss_tag  (iss_tag),
            .bus_valid(bus_valid),
            .bus_tag  (bus_tag),
            .bus_data (bus_data),
            .stat_q   (stat_flat[r]),
            .val_q    (val_flat[r])
         );
      end
   endgenerate

   regstat_read #(
      .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W), .BYPASS(BYPASS)
   ) u_rd1 (
      .idx(iss_src1), .stat_flat(stat_flat), .val_flat(val_flat),
      .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
      .ready(src1_ready), .value(src1_value), .tag(src1_tag)
   );

   regstat_read #(
      .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W), .BYPASS(BYPASS)
   ) u_rd2 (
      .idx(iss_src2), .stat_flat(stat_flat), .val_flat(val_flat),
      .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
      .ready(src2_ready), .value(src2_value), .tag(src2_tag)
   );
endmodule

// File: rtl/regstat_chk.sv
module regstat_chk #(
   parameter int NUM_REGS = 16,
   parameter int DATA_W   = 64,
   parameter int TAG_W    = 4,
   parameter bit BYPASS   = 1'b1,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             iss_valid,
   input logic [TAG_W-1:0]                 iss_tag,
   input logic [IDX_W-1:0]                 iss_dst,
   input logic [IDX_W-1:0]                 iss_src1,
   input logic                             bus_valid,
   input logic [TAG_W-1:0]                 bus_tag,
   input logic [DATA_W-1:0]                bus_data,
   input logic                             src1_ready,
   input logic [DATA_W-1:0]                src1_value,
   input logic [TAG_W-1:0]                 src1_tag,
   input logic [NUM_REGS-1:0][TAG_W-1:0]   stat_flat,
   input logic [NUM_REGS-1:0][DATA_W-1:0]  val_flat
);
   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_each
         assert_issue_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (iss_valid && iss_dst == g) |=> (stat_flat[g] == $past(iss_tag)));

         assert_match_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_valid && stat_flat[g] != '0 && bus_tag == stat_flat[g]
             && !(iss_valid && iss_dst == g)) |=> (stat_flat[g] == '0));

         assert_match_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_valid && stat_flat[g] != '0 && bus_tag == stat_flat[g])
            |=> (val_flat[g] == $past(bus_data)));

         assert_value_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !(bus_valid && stat_flat[g] != '0 && bus_tag == stat_flat[g])
            |=> $stable(val_flat[g]));

         assert_tag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!(bus_valid && stat_flat[g] != '0 && bus_tag == stat_flat[g])
             && !(iss_valid && iss_dst == g)) |=> $stable(stat_flat[g]));
      end
   endgenerate

   assert_ready_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      src1_ready |-> (src1_tag == '0));

   assert_wait_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !src1_ready |-> (src1_tag == stat_flat[iss_src1] && src1_tag != '0
                       && src1_value == val_flat[iss_src1]));

   generate
      if (BYPASS) begin : g_byp_chk
         assert_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_valid && stat_flat[iss_src1] != '0 && bus_tag == stat_flat[iss_src1])
            |-> (src1_ready && src1_value == bus_data));
      end
   endgenerate
endmodule

bind regstat_table regstat_chk #(
   .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W), .BYPASS(BYPASS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_tag(iss_tag),
   .iss_dst(iss_dst), .iss_src1(iss_src1), .bus_valid(bus_valid),
   .bus_tag(bus_tag), .bus_data(bus_data), .src1_ready(src1_ready),
   .src1_value(src1_value), .src1_tag(src1_tag),
   .stat_flat(stat_flat), .val_flat(val_flat)
);

// File: tb/regstat_table_tb.sv
module regstat_table_tb;
   localparam int NR = 16;
   localparam int DW = 64;
   localparam int TW = 4;
   localparam int IW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          iss_valid = 1'b0;
   logic [TW-1:0] iss_tag = '0;
   logic [IW-1:0] iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
   logic          src1_ready, src2_ready;
   logic [DW-1:0] src1_value, src2_value;
   logic [TW-1:0] src1_tag, src2_tag;
   logic          bus_valid = 1'b0;
   logic [TW-1:0] bus_tag = '0;
   logic [DW-1:0] bus_data = '0;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   int            m_tag [NR];
   logic [DW-1:0] m_val [NR];

   always #5 clk = ~clk;

   regstat_table u_dut (
      .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_tag(iss_tag),
      .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
      .src1_ready(src1_ready), .src1_value(src1_value), .src1_tag(src1_tag),
      .src2_ready(src2_ready), .src2_value(src2_value), .src2_tag(src2_tag),
      .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data)
   );

   task automatic check_src(input string lbl, input string which, input int idx,
                            input logic rdy, input logic [DW-1:0] val,
                            input logic [TW-1:0] tg);
      int  st;
      bit  byp;
      logic          e_rdy;
      logic [DW-1:0] e_val;
      int            e_tag;
      st    = m_tag[idx];
      byp   = bus_valid && st != 0 && int'(bus_tag) == st;
      e_rdy = (st == 0) || byp;
      e_val = byp ? bus_data : m_val[idx];
      e_tag = e_rdy ? 0 : st;
      checks++;
      if (rdy !== e_rdy || val !== e_val || int'(tg) != e_tag) begin
         fails++;
         $display("FAIL %s %s reg%0d: got ready=%b value=%h tag=%0d, expected ready=%b value=%h tag=%0d",
                  lbl, which, idx, rdy, val, tg, e_rdy, e_val, e_tag);
      end
   endtask

   task automatic model_step();
      bit hit [NR];
      for (int r = 0; r < NR; r++)
         hit[r] = bus_valid && m_tag[r] != 0 && int'(bus_tag) == m_tag[r];
      for (int r = 0; r < NR; r++) begin
         if (hit[r]) m_val[r] = bus_data;
         if (iss_valid && int'(iss_dst) == r) m_tag[r] = int'(iss_tag);
         else if (hit[r]) m_tag[r] = 0;
      end
   endtask

   // inputs are already set (at a falling edge); compare, then advance one clock
   task automatic cycle(input string lbl);
      #1;
      check_src(lbl, "src1", int'(iss_src1), src1_ready, src1_value, src1_tag);
      check_src(lbl, "src2", int'(iss_src2), src2_ready, src2_value, src2_tag);
      @(posedge clk);
      model_step();
      @(negedge clk);
   endtask

   task automatic idle();
      iss_valid = 1'b0;
      bus_valid = 1'b0;
      bus_tag   = '0;
   endtask

   initial begin
      for (int r = 0; r < NR; r++) begin m_tag[r] = 0; m_val[r] = '0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state seen at two lookups
      idle(); iss_src1 = 4'd0; iss_src2 = 4'd15;
      cycle("R1");

      // R9: issue to reg 3 while reading reg 3 shows the old (empty) state
      iss_valid = 1'b1; iss_dst = 4'd3; iss_tag = 4'd5; iss_src1 = 4'd3; iss_src2 = 4'd3;
      cycle("R9");

      // R2: reg 3 now waits for tag 5
      idle(); iss_src2 = 4'd0;
      cycle("R2");

      // R3: a second writer replaces the pending tag
      iss_valid = 1'b1; iss_dst = 4'd3; iss_tag = 4'd6;
      cycle("R3");
      idle();
      cycle("R3");

      // R4: stale broadcast from tag 5 must not touch reg 3
      bus_valid = 1'b1; bus_tag = 4'd5; bus_data = 64'hDEAD_0000_0000_0005;
      cycle("R4");
      idle();
      cycle("R4");

      // R8: broadcast with tag 0, then a bus_valid=0 cycle carrying tag 6
      bus_valid = 1'b1; bus_tag = 4'd0; bus_data = 64'h1111_2222_3333_4444;
      cycle("R8");
      bus_valid = 1'b0; bus_tag = 4'd6; bus_data = 64'h5555_6666_7777_8888;
      cycle("R8");

      // R7: matching broadcast bypasses into the lookup
      bus_valid = 1'b1; bus_tag = 4'd6; bus_data = 64'hCAFE_F00D_0123_4567;
      cycle("R7");
      // R5: tag empty and value written
      idle();
      cycle("R5");

      // R6: issue and matching broadcast to reg 7 in one cycle
      iss_valid = 1'b1; iss_dst = 4'd7; iss_tag = 4'd2; iss_src1 = 4'd7; iss_src2 = 4'd3;
      cycle("R6");
      iss_valid = 1'b1; iss_dst = 4'd7; iss_tag = 4'd3;
      bus_valid = 1'b1; bus_tag = 4'd2; bus_data = 64'h0BAD_BEEF_AAAA_5555;
      cycle("R6");
      idle();
      cycle("R6");
      bus_valid = 1'b1; bus_tag = 4'd3; bus_data = 64'h7777_0000_7777_0000;
      cycle("R7");
      idle();
      cycle("R5");

      // mixed traffic against the model
      for (int n = 0; n < 4000; n++) begin
         string lbl;
         iss_valid = ($urandom_range(0, 2) != 0);
         iss_dst   = IW'($urandom_range(0, NR - 1));
         iss_tag   = TW'($urandom_range(1, 7));
         iss_src1  = IW'($urandom_range(0, NR - 1));
         iss_src2  = IW'($urandom_range(0, NR - 1));
         bus_valid = ($urandom_range(0, 1) != 0);
         bus_tag   = TW'($urandom_range(0, 7));
         bus_data  = {$urandom(), $urandom()};
         if (bus_valid && bus_tag != 0 &&
             (m_tag[iss_src1] == int'(bus_tag) || m_tag[iss_src2] == int'(bus_tag)))
            lbl = "R7";
         else
            lbl = "R2";
         cycle(lbl);
      end
      idle();
      cycle("R4");

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule